// File: doc/BRIEF.md
# Sequential Next-Line Prefetch Unit

This unit sits beside a line-based cache and watches its demand accesses. For every access it works out the line that follows it in sequence. Depending on a runtime trigger policy, it then places that line in a small request queue toward the memory side. Prefetching can be turned off. It can also be triggered on every access, only on misses, or on misses plus the first demand hit to a line that an earlier prefetch brought in (tagged policy).

The candidate line is sent out on a lookup port, and the cache answers in the same cycle whether it already holds that line. A candidate is dropped in four cases: the line is already cached, it is already waiting in the queue, the queue is full, or the increment would wrap past the top of the line address space. The unit never stalls demand accesses. Each queued request carries a flag that the cache stores with the filled line. The unit also drives a strobe that tells the cache to clear that flag on the first demand hit to the line, so each prefetched line can start at most one further prefetch.

Top module: `nextline_pf`

## Requirements
- R1: After reset the request queue is empty: `req_valid` is 0.
- R2: The candidate on `look_line`, and the line of any request it produces, is `acc_line + 1`, including the carry across lower bits (0x12FF gives 0x1300).
- R3: With `mode` = 0 (off), no access enqueues a request.
- R4: With `mode` = 1 (always), every valid access, hit or miss, enqueues a request.
- R5: With `mode` = 2 (on miss), only an access with `acc_hit` = 0 enqueues a request. Hits do not, whatever the value of `acc_pf_tag`.
- R6: With `mode` = 3 (tagged), a miss enqueues a request, and so does a hit with `acc_pf_tag` = 1. A hit with `acc_pf_tag` = 0 does not.
- R7: A candidate for which `look_present` is 1 in the access cycle is dropped.
- R8: A candidate equal to a line already waiting in the queue is dropped, so the queue holds no duplicates.
- R9: The queue holds 4 requests. A candidate that arrives while 4 are waiting is dropped, and the queued requests are unchanged.
- R10: An access to the all-ones line address enqueues nothing.
- R11: Requests leave in arrival order, one per cycle with `req_valid` and `req_ready` both 1. While `req_ready` is 0, `req_valid` and `req_line` hold.
- R12: `req_tag` is 1 on requests enqueued in tagged mode and 0 otherwise. `tag_clear` is 1 in exactly the cycles with a valid access where `acc_hit` = 1 and `acc_pf_tag` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Trigger policy: 0 off, 1 always, 2 on miss, 3 tagged |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_line | input | LINE_W | Line address of the demand access |
| acc_hit | input | 1 | The demand access hit in the cache |
| acc_pf_tag | input | 1 | The hit line still carries its prefetched flag |
| look_line | output | LINE_W | Candidate line sent to the cache lookup |
| look_present | input | 1 | The cache already holds `look_line` (same cycle) |
| tag_clear | output | 1 | Clear the prefetched flag of the accessed line |
| req_valid | output | 1 | A prefetch request is waiting |
| req_line | output | LINE_W | Line address of the oldest request |
| req_tag | output | 1 | Flag to store with the line once it is filled |
| req_ready | input | 1 | The memory side takes the request this cycle |

## Verification
The hardest situations to reach are the two queue-side drops. Both need `req_ready` held low so that earlier requests stay in place. For the duplicate drop, two accesses to the same line are made back to back while the queue is stalled. For the full drop, five accesses to distinct lines are made while it is stalled. Draining the queue afterwards, one entry per cycle, shows through `req_line` and `req_valid` exactly which candidates were kept and in what order. The policy behaviour is walked through from a vector table in which each access is followed by a single pop cycle, so that each case starts from an empty queue.

// File: rtl/pf_pkg.sv
// Package: shared trigger-policy encoding for the next-line prefetch unit.
package pf_pkg;
    typedef enum logic [1:0] {
        PF_OFF    = 2'd0,
        PF_ALWAYS = 2'd1,
        PF_MISS   = 2'd2,
        PF_TAGGED = 2'd3
    } pf_mode_e;
endpackage

// File: rtl/pf_trigger.sv
// Module: pf_trigger
// Decides whether the current demand access should start a prefetch under
// the selected policy. Purely combinational; assumes acc_pf_tag is only
// meaningful together with acc_hit.
module pf_trigger
    import pf_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       acc_valid,
    input  logic       acc_hit,
    input  logic       acc_pf_tag,
    output logic       fire
);
    // Policy decode
    always_comb begin
        fire = 1'b0;
        case (pf_mode_e'(mode))
            PF_OFF:    fire = 1'b0;
            PF_ALWAYS: fire = acc_valid;
            PF_MISS:   fire = acc_valid && !acc_hit;
            PF_TAGGED: fire = acc_valid && (!acc_hit || acc_pf_tag);
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/pf_queue.sv
// Module: pf_queue
// Circular request queue of DEPTH entries with a content match on the
// address field of occupied entries. Assumes DEPTH is a power of two and
// that the caller never pushes while full.
module pf_queue #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic              push_tag,
    input  logic              pop,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit,
    output logic              full,
    output logic              empty,
    output logic [LINE_W-1:0] head_line,
    output logic              head_tag
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [LINE_W-1:0] line_q [DEPTH];
    logic              tag_q  [DEPTH];
    logic [PW-1:0]     rd_ptr, wr_ptr;
    logic [CW-1:0]     count;
    logic [DEPTH-1:0]  match;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_line = line_q[rd_ptr];
    assign head_tag  = tag_q[rd_ptr];
    assign probe_hit = |match;

    // Per-entry occupancy and address compare
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        logic [PW-1:0] offs;
        assign offs     = PW'(i) - rd_ptr;
        assign match[i] = ({1'b0, offs} < count) && (line_q[i] == probe_line);
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push) begin
            line_q[wr_ptr] <= push_line;
            tag_q[wr_ptr]  <= push_tag;
        end
    end
endmodule

// File: rtl/nextline_pf.sv
// Module: nextline_pf
// One-block-lookahead prefetch unit. Forms the next sequential line of each
// demand access, filters it (policy, cache presence, queue duplicate,
// queue full, address wrap) and queues survivors toward memory.
// Assumes look_present answers combinationally for look_line.
module nextline_pf
    import pf_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              acc_hit,
    input  logic              acc_pf_tag,
    output logic [LINE_W-1:0] look_line,
    input  logic              look_present,
    output logic              tag_clear,
    output logic              req_valid,
    output logic [LINE_W-1:0] req_line,
    output logic              req_tag,
    input  logic              req_ready
);
    logic fire, wrap, in_q, q_full, q_empty, push_w, pop_w;

    pf_trigger u_trig (
        .mode       (mode),
        .acc_valid  (acc_valid),
        .acc_hit    (acc_hit),
        .acc_pf_tag (acc_pf_tag),
        .fire       (fire)
    );

    // Candidate formation and filtering
    assign look_line = acc_line + 1'b1;
    assign wrap      = &acc_line;
    assign push_w    = fire && !wrap && !look_present && !in_q && !q_full;
    assign pop_w     = req_valid && req_ready;
    assign req_valid = !q_empty;
    assign tag_clear = acc_valid && acc_hit && acc_pf_tag;

    pf_queue #(.DEPTH(QDEPTH), .LINE_W(LINE_W)) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_w),
        .push_line  (look_line),
        .push_tag   (mode == 2'(PF_TAGGED)),
        .pop        (pop_w),
        .probe_line (look_line),
        .probe_hit  (in_q),
        .full       (q_full),
        .empty      (q_empty),
        .head_line  (req_line),
        .head_tag   (req_tag)
    );
endmodule

// File: rtl/pf_chk.sv
// Module: pf_chk
// Property checker for nextline_pf, attached by bind; observes ports and
// the internal enqueue strobe.
module pf_chk #(
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              acc_hit,
    input logic [LINE_W-1:0] acc_line,
    input logic              look_present,
    input logic              push,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LINE_W-1:0] req_line
);
    // R3
    off_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !push);
    // R5
    miss_mode_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && acc_hit) |-> !push);
    // R7
    present_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        look_present |-> !push);
    // R10
    wrap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&acc_line) |-> !push);
    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));
endmodule

bind nextline_pf pf_chk #(.LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .acc_hit      (acc_hit),
    .acc_line     (acc_line),
    .look_present (look_present),
    .push         (push_w),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_line     (req_line)
);

// File: tb/nextline_pf_bench.sv
module nextline_pf_bench;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = '0;
    logic          acc_valid = 1'b0, acc_hit = 1'b0, acc_pf_tag = 1'b0;
    logic [LW-1:0] acc_line = '0;
    logic          look_present = 1'b0, req_ready = 1'b0;
    logic [LW-1:0] look_line, req_line;
    logic          tag_clear, req_valid, req_tag;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nextline_pf #(.LINE_W(LW), .QDEPTH(4)) u_nextline_pf (.*);

    // Vector: {mode[2], hit, tag, present, expect_push, line[16]}
    localparam int NV = 11;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0010},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0020},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0200},
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0300},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0400},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0500},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0600},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0700},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0800},
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h12FF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] m, input logic p);
        if (p) return "R7";
        case (m)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Present one access at a negedge, hold for one edge, then idle.
    task automatic access(input logic [1:0] m, input logic [LW-1:0] ln,
                          input logic h, input logic t, input logic p);
        mode = m; acc_line = ln; acc_hit = h; acc_pf_tag = t;
        look_present = p; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; look_present = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 reset empty", req_valid, 0);

        // Policy table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0]    m;
            logic          h, t, p, e;
            logic [LW-1:0] ln;
            {m, h, t, p, e, ln} = VEC[v];
            mode = m; acc_line = ln; acc_hit = h; acc_pf_tag = t;
            look_present = p; acc_valid = 1'b1; req_ready = 1'b0;
            #1;
            chk(look_line == ln + 1'b1, "R2 look_line", look_line, ln + 1'b1);
            chk(tag_clear == (h && t), "R12 tag_clear", tag_clear, h && t);
            @(negedge clk);
            acc_valid = 1'b0; look_present = 1'b0;
            chk(req_valid == e, req_of(m, p), req_valid, e);
            if (e) begin
                chk(req_line == ln + 1'b1, "R2 req_line", req_line, ln + 1'b1);
                chk(req_tag == (m == 2'd3), "R12 req_tag", req_tag, m == 2'd3);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(req_valid == 1'b0, "R11 pop empties", req_valid, 0);
        end

        // R8: duplicate candidate while the first waits
        access(2'd1, 16'h2000, 1'b0, 1'b0, 1'b0);
        access(2'd1, 16'h2000, 1'b1, 1'b0, 1'b0);
        chk(req_valid && req_line == 16'h2001, "R8 first kept", req_line, 16'h2001);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(req_valid == 1'b0, "R8 duplicate dropped", req_valid, 0);

        // R9 / R11: fill to four, fifth dropped, drain in order with stall
        for (int k = 0; k < 5; k++)
            access(2'd2, LW'(16'h3000 + 16'h10 * k), 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(req_line == 16'h3001, "R11 head held while stalled", req_line, 16'h3001);
        for (int k = 0; k < 4; k++) begin
            chk(req_valid && req_line == LW'(16'h3001 + 16'h10 * k), "R9 R11 drain order",
                req_line, 16'h3001 + 16'h10 * k);
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
        end
        chk(req_valid == 1'b0, "R9 fifth dropped when full", req_valid, 0);

        // R10: top line never wraps into a request
        access(2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        chk(req_valid == 1'b0, "R10 wrap dropped", req_valid, 0);

        // R1: reset clears a pending request
        access(2'd1, 16'h4000, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_valid == 1'b0, "R1 reset clears queue", req_valid, 0);

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule